// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block takes in 8-bit or 9-bit characters from a data line that is clocked by an external master. The external clock and data pass through a synchroniser into the system clock domain. The sampling edge is rising or falling, as a polarity control selects. Bits arrive least significant first. They collect in a shift register, and each finished word moves into a two-entry receive FIFO.

Software sees the head of the FIFO as a low byte plus a separate ninth bit. It reads the ninth bit first, then pulses a pop strobe to take the entry away. A completion flag stays high while any word is waiting. An interrupt request follows that flag whenever the receive interrupt enable is set.

If a word finishes while the FIFO is full, a sticky overrun flag is set. Nothing more is accepted until the flag is cleared, either by dropping continuous receive or by disabling the port. Disabling the port also flushes the FIFO.

Top module: `sync_slave_rx`

## Requirements
- R1: Words are collected only when port_en=1, sync_mode=1 and clk_master=0. Under any other combination, no word reaches the FIFO.
- R2: Reception requires cont_rx_en=1. single_rx_en has no effect: with cont_rx_en=0 nothing is received whatever its value, and with cont_rx_en=1 it changes nothing.
- R3: With nine_bit_sel=0, a word is 8 bits sent least significant first. rx_data holds the byte and rx_bit9 is 0.
- R4: With nine_bit_sel=1, a word is 9 bits. The first 8 bits go to rx_data (LSB first) and the ninth bit goes to rx_bit9.
- R5: With clk_pol=0, data is sampled on rising ext_clk edges. With clk_pol=1, it is sampled on falling edges.
- R6: The FIFO holds 2 words in arrival order. rx_done is 1 exactly while it is not empty. A one-cycle rd_pop removes the head entry.
- R7: A word that completes while the FIFO is full sets rx_overrun and is discarded. While rx_overrun=1, later words are discarded even if space exists.
- R8: Dropping cont_rx_en clears rx_overrun and keeps the FIFO contents. Dropping port_en clears rx_overrun and empties the FIFO.
- R9: rx_irq equals rx_done AND rx_int_en, delayed by one clock.
- R10: The bit counter holds at zero while reception is off, so a 0-to-1 change of cont_rx_en starts a fresh word. The word length is taken from nine_bit_sel at the first bit of each word.
- R11: After reset, rx_done, rx_overrun, rx_irq, rx_bit9 and rx_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Shift clock from the external master |
| ext_data | input | 1 | Serial data line |
| port_en | input | 1 | Port enable; low resets the receiver |
| sync_mode | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Clock-source select; 0 means slave |
| cont_rx_en | input | 1 | Continuous receive enable |
| single_rx_en | input | 1 | Single receive enable, ignored in slave mode |
| nine_bit_sel | input | 1 | 1 selects 9-bit words |
| clk_pol | input | 1 | 0 samples on rising edge, 1 on falling edge |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_pop | input | 1 | One-cycle strobe that removes the FIFO head |
| rx_data | output | 8 | Low byte of FIFO head |
| rx_bit9 | output | 1 | Ninth bit of FIFO head |
| rx_done | output | 1 | FIFO holds at least one word |
| rx_overrun | output | 1 | Sticky overrun error |
| rx_irq | output | 1 | Interrupt / wake request |

## Verification
The assertions assume three things about the inputs:
- ext_clk stays at each level for several system clocks, so every level survives the synchroniser and yields exactly one edge pulse.
- ext_data is stable around the sampling edge.
- rd_pop is a single-cycle strobe.

The stimulus holds each ext_clk half period for six system clocks and changes data only at the inactive level. It changes clk_pol only while the line is idle, and re-arms the bit counter by toggling cont_rx_en between scenarios.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int RX_LO_W   = 8;
  localparam int RX_DEPTH  = 2;
  localparam int RX_STAGES = 2;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } sample_edge_e;
endpackage

// File: rtl/sync_rx_edge.sv
module sync_rx_edge
  import sync_rx_pkg::*;
#(
  parameter int STAGES = RX_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  input  logic ext_data,
  input  logic clk_pol,
  output logic sample,
  output logic data_s
);
  logic [STAGES-1:0] clk_chain;
  logic [STAGES-1:0] dat_chain;
  logic              clk_last;
  logic              rise, fall;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            clk_chain[0] <= 1'b0;
            dat_chain[0] <= 1'b0;
          end else begin
            clk_chain[0] <= ext_clk;
            dat_chain[0] <= ext_data;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            clk_chain[g] <= 1'b0;
            dat_chain[g] <= 1'b0;
          end else begin
            clk_chain[g] <= clk_chain[g-1];
            dat_chain[g] <= dat_chain[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clk_last <= 1'b0;
    else     clk_last <= clk_chain[STAGES-1];
  end

  assign rise   = clk_chain[STAGES-1] & ~clk_last;
  assign fall   = ~clk_chain[STAGES-1] & clk_last;
  assign sample = (sample_edge_e'(clk_pol) == EDGE_FALL) ? fall : rise;
  assign data_s = dat_chain[STAGES-1];

  // R5: a single synchronised level change gives at most one pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sample |=> !sample);
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift
  import sync_rx_pkg::*;
#(
  parameter int LO_W = RX_LO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          sample,
  input  logic          din,
  input  logic          nine_sel,
  output logic          word_done,
  output logic [LO_W:0] word_data
);
  localparam int WW    = LO_W + 1;
  localparam int CNT_W = $clog2(WW + 1);
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(LO_W - 1);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(LO_W);

  logic [LO_W:0]    sr_q, sr_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             len9_q;
  logic             len9_now;
  logic             last_bit;

  assign len9_now = (cnt_q == '0) ? nine_sel : len9_q;
  assign sr_nx    = {din, sr_q[LO_W:1]};
  assign last_bit = (cnt_q == (len9_now ? LAST9 : LAST8));

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      sr_q      <= '0;
      cnt_q     <= '0;
      len9_q    <= 1'b0;
      word_done <= 1'b0;
      word_data <= '0;
    end else begin
      word_done <= 1'b0;
      if (sample) begin
        sr_q   <= sr_nx;
        len9_q <= len9_now;
        if (last_bit) begin
          cnt_q     <= '0;
          word_done <= 1'b1;
          word_data <= len9_now ? sr_nx : {1'b0, sr_nx[LO_W:1]};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R10: counter never passes the last bit of a 9-bit word
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST9);
  // R1: nothing completes once reception is off
  a_r1_no_done_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !word_done);
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo
  import sync_rx_pkg::*;
#(
  parameter int W     = RX_LO_W + 1,
  parameter int DEPTH = RX_DEPTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = empty ? '0 : mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_FULL);

  // R7: writer never pushes into a full buffer
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R6: occupancy bounded by depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_FULL);
  // R6: popping the last entry empties the buffer
  a_r6_last_pop: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count == 1) |=> empty);
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int LO_W   = RX_LO_W,
  parameter int DEPTH  = RX_DEPTH,
  parameter int STAGES = RX_STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_clk,
  input  logic            ext_data,
  input  logic            port_en,
  input  logic            sync_mode,
  input  logic            clk_master,
  input  logic            cont_rx_en,
  input  logic            single_rx_en,
  input  logic            nine_bit_sel,
  input  logic            clk_pol,
  input  logic            rx_int_en,
  input  logic            rd_pop,
  output logic [LO_W-1:0] rx_data,
  output logic            rx_bit9,
  output logic            rx_done,
  output logic            rx_overrun,
  output logic            rx_irq
);
  localparam int WW = LO_W + 1;

  logic          slave_active, rx_enable;
  logic          sample, data_s;
  logic          word_done;
  logic [WW-1:0] word_data, head;
  logic          f_empty, f_full, f_push, f_pop;
  logic          unused_single;

  // single receive has no meaning for a slave
  assign unused_single = single_rx_en;

  assign slave_active = port_en & sync_mode & ~clk_master;
  assign rx_enable    = slave_active & cont_rx_en;

  sync_rx_edge #(.STAGES(STAGES)) edge_i (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .ext_data(ext_data),
    .clk_pol(clk_pol), .sample(sample), .data_s(data_s)
  );

  sync_rx_shift #(.LO_W(LO_W)) shift_i (
    .clk(clk), .rst(rst), .enable(rx_enable), .sample(sample),
    .din(data_s), .nine_sel(nine_bit_sel),
    .word_done(word_done), .word_data(word_data)
  );

  assign f_push = word_done & rx_enable & ~rx_overrun & ~f_full;
  assign f_pop  = rd_pop & ~f_empty;

  sync_rx_fifo #(.W(WW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .clear(~port_en), .push(f_push),
    .wdata(word_data), .pop(f_pop), .rdata(head),
    .empty(f_empty), .full(f_full)
  );

  always_ff @(posedge clk) begin
    if (rst || !rx_enable)                  rx_overrun <= 1'b0;
    else if (word_done && f_full)           rx_overrun <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !port_en) rx_irq <= 1'b0;
    else                 rx_irq <= ~f_empty & rx_int_en;
  end

  assign rx_done = ~f_empty;
  assign rx_data = head[LO_W-1:0];
  assign rx_bit9 = head[LO_W];

  // R7: overrun stays while reception remains on
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && rx_enable) |=> rx_overrun);
  // R8: turning reception off clears overrun
  a_r8_overrun_clear: assert property (@(posedge clk) disable iff (rst)
    !rx_enable |=> !rx_overrun);
  // R8: port disable empties the FIFO
  a_r8_port_flush: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> !rx_done);
  // R9: request follows completion flag and enable by one clock
  a_r9_irq_follow: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_int_en && port_en) |=> rx_irq);
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (!rx_done || !rx_int_en) |=> !rx_irq);
endmodule

// File: tb/sync_slave_rx_tb.sv
module sync_slave_rx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_clk = 1'b0, ext_data = 1'b0;
  logic port_en = 1'b1, sync_mode = 1'b1, clk_master = 1'b0;
  logic cont_rx_en = 1'b1, single_rx_en = 1'b0, nine_bit_sel = 1'b0;
  logic clk_pol = 1'b0, rx_int_en = 1'b0, rd_pop = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9, rx_done, rx_overrun, rx_irq;

  int n_checks = 0;
  int n_fail   = 0;
  localparam int HALF = 6;

  always #5 clk = ~clk;

  sync_slave_rx dut_i (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .ext_data(ext_data),
    .port_en(port_en), .sync_mode(sync_mode), .clk_master(clk_master),
    .cont_rx_en(cont_rx_en), .single_rx_en(single_rx_en),
    .nine_bit_sel(nine_bit_sel), .clk_pol(clk_pol), .rx_int_en(rx_int_en),
    .rd_pop(rd_pop), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_done(rx_done), .rx_overrun(rx_overrun), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift bits lo..hi of w, LSB first, using the active edge of clk_pol
  task automatic send_bits(input logic [8:0] w, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      ext_data = w[i];
      wait_n(HALF);
      ext_clk = ~clk_pol;
      wait_n(HALF);
      ext_clk = clk_pol;
    end
    wait_n(8);
  endtask

  task automatic pop_one();
    rd_pop = 1'b1;
    wait_n(1);
    rd_pop = 1'b0;
    wait_n(2);
  endtask

  task automatic rearm();
    cont_rx_en = 1'b0;
    wait_n(4);
    cont_rx_en = 1'b1;
    wait_n(4);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) if (rx_done) pop_one();
  endtask

  task automatic t_reset();
    check("R11", "rx_done", rx_done, 0);
    check("R11", "rx_overrun", rx_overrun, 0);
    check("R11", "rx_irq", rx_irq, 0);
    check("R11", "rx_data", rx_data, 0);
    check("R11", "rx_bit9", rx_bit9, 0);
  endtask

  task automatic t_byte();
    send_bits(9'h0A5, 0, 7);
    check("R3", "rx_done", rx_done, 1);
    check("R3", "rx_data", rx_data, 8'hA5);
    check("R3", "rx_bit9", rx_bit9, 0);
    pop_one();
    check("R6", "rx_done after pop", rx_done, 0);
  endtask

  task automatic t_nine();
    nine_bit_sel = 1'b1;
    send_bits(9'h13C, 0, 8);
    nine_bit_sel = 1'b0;
    check("R4", "rx_bit9", rx_bit9, 1);
    check("R4", "rx_data", rx_data, 8'h3C);
    pop_one();
  endtask

  task automatic t_pol();
    clk_pol = 1'b1;
    wait_n(2);
    ext_clk = 1'b1;
    wait_n(8);
    rearm();
    send_bits(9'h05A, 0, 7);
    check("R5", "falling-edge data", rx_data, 8'h5A);
    pop_one();
    clk_pol = 1'b0;
    wait_n(2);
    ext_clk = 1'b0;
    wait_n(8);
    rearm();
    send_bits(9'h0C3, 0, 7);
    check("R5", "rising-edge data", rx_data, 8'hC3);
    pop_one();
  endtask

  task automatic t_fifo_order();
    send_bits(9'h011, 0, 7);
    send_bits(9'h022, 0, 7);
    check("R6", "head first", rx_data, 8'h11);
    pop_one();
    check("R6", "done with one left", rx_done, 1);
    check("R6", "head second", rx_data, 8'h22);
    pop_one();
    check("R6", "empty", rx_done, 0);
  endtask

  task automatic t_overrun_and_clear();
    send_bits(9'h031, 0, 7);
    send_bits(9'h032, 0, 7);
    check("R7", "no overrun when just full", rx_overrun, 0);
    send_bits(9'h033, 0, 7);
    check("R7", "overrun set", rx_overrun, 1);
    check("R7", "head kept", rx_data, 8'h31);
    pop_one();
    pop_one();
    check("R7", "third word dropped", rx_done, 0);
    send_bits(9'h034, 0, 7);
    check("R7", "word dropped while overrun", rx_done, 0);
    check("R7", "overrun still set", rx_overrun, 1);
    cont_rx_en = 1'b0;
    wait_n(3);
    check("R8", "overrun cleared by cont_rx_en", rx_overrun, 0);
    cont_rx_en = 1'b1;
    wait_n(3);
    send_bits(9'h041, 0, 7);
    send_bits(9'h042, 0, 7);
    send_bits(9'h043, 0, 7);
    check("R7", "overrun again", rx_overrun, 1);
    cont_rx_en = 1'b0;
    wait_n(3);
    check("R8", "fifo kept on cont_rx_en drop", rx_data, 8'h41);
    cont_rx_en = 1'b1;
    send_bits(9'h044, 0, 7);
    check("R7", "overrun from full again", rx_overrun, 1);
    port_en = 1'b0;
    wait_n(3);
    check("R8", "port disable clears overrun", rx_overrun, 0);
    check("R8", "port disable flushes", rx_done, 0);
    port_en = 1'b1;
    wait_n(3);
  endtask

  task automatic t_gating();
    cont_rx_en = 1'b0;
    single_rx_en = 1'b1;
    wait_n(3);
    send_bits(9'h0F0, 0, 7);
    check("R2", "no word with cont_rx_en low", rx_done, 0);
    cont_rx_en = 1'b1;
    wait_n(3);
    send_bits(9'h0E7, 0, 7);
    check("R2", "single_rx_en no effect", rx_data, 8'hE7);
    single_rx_en = 1'b0;
    pop_one();
    clk_master = 1'b1;
    wait_n(3);
    send_bits(9'h0AA, 0, 7);
    check("R1", "master select blocks", rx_done, 0);
    clk_master = 1'b0;
    sync_mode = 1'b0;
    wait_n(3);
    send_bits(9'h0AA, 0, 7);
    check("R1", "async mode blocks", rx_done, 0);
    sync_mode = 1'b1;
    wait_n(3);
  endtask

  task automatic t_irq();
    rx_int_en = 1'b1;
    send_bits(9'h066, 0, 7);
    check("R9", "irq with enable", rx_irq, 1);
    rx_int_en = 1'b0;
    wait_n(2);
    check("R9", "irq off without enable", rx_irq, 0);
    rx_int_en = 1'b1;
    pop_one();
    check("R9", "irq off when empty", rx_irq, 0);
    rx_int_en = 1'b0;
  endtask

  task automatic t_restart_latch();
    send_bits(9'h1FF, 0, 2);
    rearm();
    send_bits(9'h03C, 0, 7);
    check("R10", "restart on cont_rx_en rise", rx_data, 8'h3C);
    pop_one();
    send_bits(9'h0C6, 0, 1);
    nine_bit_sel = 1'b1;
    send_bits(9'h0C6, 2, 7);
    check("R10", "length latched at word start", rx_done, 1);
    check("R10", "latched word data", rx_data, 8'hC6);
    check("R10", "latched word bit9", rx_bit9, 0);
    nine_bit_sel = 1'b0;
    pop_one();
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    t_reset();
    t_byte();
    t_nine();
    t_pol();
    t_fifo_order();
    t_overrun_and_clear();
    t_gating();
    t_irq();
    t_restart_latch();
    drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule